// File: doc/BRIEF.md
# Page-Bounded Serial DMA Channel

This block moves data between memory and one serial port. It has a transmit direction and a receive direction. The transmit side reads 32-bit words from memory and sends them to the serial transmitter as bytes. The receive side gathers bytes from the serial receiver into words and writes them to memory. Each direction takes its memory position from a pointer register. The pointer is kept in a rotated form: the low three bits of the register hold the top three address bits. A transfer never runs past the end of the 4 KiB page in which it starts.

Software controls the block through a small register bus. A write to the control register starts the directions whose enable bits are set. When a transmit transfer reaches the end of its page, it disables itself, moves its pointer to the start of the next page and flags the event. The receive side keeps its enable bit. It flags each crossing of a 2 KiB boundary. It ends at the page end, or when the receiver reports idle. On idle, any partly filled word is first written with only its valid byte lanes enabled. Status bits are cleared by writing 1 to them. A mask register selects which status bits drive the interrupt line.

Top module: `sdma_chan`

## Requirements
- R1: Registers sit in 16-byte slots selected by regAddr[7:4]: 0x00 control (bit 0 transmit enable, bit 1 receive enable), 0x10 transmit pointer, 0x20 receive pointer, 0x30 status (bit 0 transmit page end, bit 1 receive half page), 0x40 mask (same bit positions as status). Unused bits and unused slots read as 0. Every register is 0 after reset.
- R2: An access with regAddr[3:0] nonzero is misaligned. A misaligned write changes nothing, and a misaligned read returns 0.
- R3: A pointer register value P stands for the address {P[2:0], P[31:3]}. When the hardware updates a pointer to address A, it stores {A[28:2], 2'b00, A[31:29]}.
- R4: Any aligned write to the control register clears status bit 0. A transmit completion in the same cycle still sets the bit.
- R5: A control write with bit 0 set, while transmit is idle and the pointer's page offset A[11:0] is nonzero, starts a transfer. The transfer reads every word from A with bits 1:0 cleared up to the last word of the page. That is 0x1000 minus (A & 0xFFC) bytes. Each word is sent least significant byte first on txValid/txReady.
- R6: If the transmit pointer's page offset is zero, a control write with bit 0 set starts nothing, and the enable bit stays set.
- R7: At the end of a transmit transfer, status bit 0 is set, control bit 0 is cleared, and the pointer is updated to (A | 0xFFF) + 1.
- R8: A control write with bit 1 set arms the receiver. Bytes are packed least significant byte first into words. Each full word is written with all four byte enables at the word address of the pointer. The pointer then advances by 4, and control bit 1 stays set.
- R9: After the receiver writes the last word of a page, rxReady stays low until a later control write re-arms the receiver.
- R10: While armed, a high rxIdle makes rxReady low. A partial word of n bytes is written with byte enables for the low n lanes, and the pointer advances by n. The receive transfer then ends.
- R11: Status bit 1 is set whenever a receive pointer advance changes address bit 11.
- R12: A write to the status register clears each bit written as 1 and leaves the other bits unchanged.
- R13: irq is high exactly when status AND mask is nonzero. A mask write changes irq from the cycle after the write.
- R14: The memory port carries one request at a time. memGnt accepts it. A pending receive write has priority over a transmit read and is held until granted. Read data returns on memRvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Write byte enables |
| memGnt | input | 1 | Request accepted this cycle |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| txValid | output | 1 | Transmit byte valid |
| txReady | input | 1 | Serial transmitter accepts byte |
| txData | output | 8 | Transmit byte |
| rxValid | input | 1 | Received byte valid |
| rxReady | output | 1 | Block accepts a received byte |
| rxData | input | 8 | Received byte |
| rxIdle | input | 1 | Receiver line idle, flush request |

## Verification
Some properties are checked by assertions on every cycle. A transmit byte holds steady while it waits for txReady. A receive write holds its address until it is granted. Byte enables are always a contiguous low run. rxReady drops once a receive transfer has ended. The status and control bits react on the cycle after each completion, half-page crossing, control write or status clear. The bench scenarios are needed for the rest: the exact transmit byte order and length for aligned and unaligned start offsets, the rotated pointer values after transmit and receive, the memory contents after a partial flush, and correct data on both directions when they share the memory port.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam int unsigned SLOT_CTRL  = 0;
  localparam int unsigned SLOT_TXPTR = 1;
  localparam int unsigned SLOT_RXPTR = 2;
  localparam int unsigned SLOT_STAT  = 3;
  localparam int unsigned SLOT_MASK  = 4;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_WAIT, TX_SEND} txState_e;

  // control -> datapath
  typedef struct packed {
    logic txPtrWr;
    logic rxPtrWr;
    logic txStart;
    logic txReq;
    logic txWordLd;
    logic txSend;
    logic txNext;
    logic txFinish;
    logic rxArmed;
  } dmaStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic txOffZero;
    logic txLastWord;
    logic txLaneLast;
    logic txGntOk;
    logic rxHalf;
    logic rxEnd;
  } dmaStatus_t;

  function automatic logic [31:0] ptrDecode(input logic [31:0] r);
    return {r[2:0], r[31:3]};
  endfunction

  function automatic logic [31:0] ptrEncode(input logic [31:0] a);
    return {a[28:2], 2'b00, a[31:29]};
  endfunction

endpackage

// File: rtl/sdma_dpath.sv
module sdma_dpath
  import sdma_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  dmaStrobe_t  stb,
  input  logic [31:0] wrData,
  output dmaStatus_t  st,
  output logic [31:0] txPtr,
  output logic [31:0] rxPtr,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  input  logic        memGnt,
  input  logic        memRvalid,
  input  logic [31:0] memRdata,
  output logic        txValid,
  input  logic        txReady,
  output logic [7:0]  txData,
  input  logic        rxValid,
  output logic        rxReady,
  input  logic [7:0]  rxData,
  input  logic        rxIdle
);
  localparam int unsigned HALF_BIT  = PAGE_BITS - 1;
  localparam logic [31:0] PAGE_MASK = (32'd1 << PAGE_BITS) - 32'd1;
  localparam int unsigned LANES     = 4;

  logic [31:0] txPtrQ, rxPtrQ, txCur, txWord, txDec, rxBase, rxNext, nextPage;
  logic [1:0]  txLane;
  logic [31:0] rxBuf;
  logic [2:0]  rxCnt;
  logic        rxPend, rxFlush, rxAccept, rxWrDone, idleEmpty;
  logic [3:0]  rxBe;

  assign txDec    = ptrDecode(txPtrQ);
  assign rxBase   = ptrDecode(rxPtrQ) & ~32'd3;
  assign rxNext   = rxBase + {29'd0, rxCnt};
  assign nextPage = (txCur | PAGE_MASK) + 32'd1;

  assign rxReady   = stb.rxArmed && !rxPend && !rxIdle;
  assign rxAccept  = rxValid && rxReady;
  assign rxWrDone  = rxPend && memGnt;
  assign idleEmpty = stb.rxArmed && !rxPend && rxIdle && (rxCnt == 3'd0);

  assign st.txOffZero  = (txDec[PAGE_BITS-1:0] == '0);
  assign st.txLastWord = &txCur[PAGE_BITS-1:2];
  assign st.txLaneLast = (txLane == 2'd3);
  assign st.txGntOk    = memGnt && !rxPend;
  assign st.rxHalf     = rxWrDone && (rxBase[HALF_BIT] != rxNext[HALF_BIT]);
  assign st.rxEnd      = (rxWrDone && (rxFlush || rxNext[PAGE_BITS-1:0] == '0)) || idleEmpty;

  assign txPtr = txPtrQ;
  assign rxPtr = rxPtrQ;

  // pointer registers: hardware updates win over bus writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPtrQ <= '0;
      rxPtrQ <= '0;
    end else begin
      if (stb.txFinish)     txPtrQ <= ptrEncode(nextPage);
      else if (stb.txPtrWr) txPtrQ <= wrData;
      if (rxWrDone)         rxPtrQ <= ptrEncode(rxNext);
      else if (stb.rxPtrWr) rxPtrQ <= wrData;
    end
  end

  // transmit word fetch and byte unpacking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCur  <= '0;
      txWord <= '0;
      txLane <= '0;
    end else begin
      if (stb.txStart)     txCur <= txDec & ~32'd3;
      else if (stb.txNext) txCur <= txCur + 32'd4;
      if (stb.txWordLd) begin
        txWord <= memRdata;
        txLane <= 2'd0;
      end else if (stb.txSend && txReady) begin
        txLane <= txLane + 2'd1;
      end
    end
  end

  assign txValid = stb.txSend;
  assign txData  = txWord[{txLane, 3'b000} +: 8];

  // receive byte packing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf   <= '0;
      rxCnt   <= '0;
      rxPend  <= 1'b0;
      rxFlush <= 1'b0;
    end else if (rxWrDone) begin
      rxCnt   <= '0;
      rxPend  <= 1'b0;
      rxFlush <= 1'b0;
    end else if (rxAccept) begin
      rxBuf[{rxCnt[1:0], 3'b000} +: 8] <= rxData;
      rxCnt <= rxCnt + 3'd1;
      if (rxCnt == 3'd3) rxPend <= 1'b1;
    end else if (stb.rxArmed && !rxPend && rxIdle && rxCnt != 3'd0) begin
      rxPend  <= 1'b1;
      rxFlush <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_be
    assign rxBe[g] = (rxCnt > 3'(g));
  end

  // single memory port, receive write first
  assign memReq   = rxPend || stb.txReq;
  assign memWe    = rxPend;
  assign memAddr  = rxPend ? rxBase : txCur;
  assign memWdata = rxBuf;
  assign memBe    = rxPend ? rxBe : 4'hF;

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
  a_r14_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memGnt) |=> (memReq && memWe && $stable(memAddr)));
  a_r10_be_contig: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memBe == 4'h1 || memBe == 4'h3 || memBe == 4'h7 || memBe == 4'hF));
  a_r9_stop_after_end: assert property (@(posedge clk) disable iff (!rstN)
    st.rxEnd |=> !rxReady);

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [1:0]        wdataLo,
  input  logic [31:0]       txPtr,
  input  logic [31:0]       rxPtr,
  input  dmaStatus_t        st,
  input  logic              memRvalid,
  input  logic              txReady,
  output dmaStrobe_t        stb,
  output logic [31:0]       regRdata,
  output logic              irq
);
  localparam int unsigned SLOT_W = REG_AW - 4;

  logic [SLOT_W-1:0] slot;
  logic aligned, wrCtrl, wrTxp, wrRxp, wrStat, wrMask, txStartC;
  logic [1:0] ctrlQ, statQ, maskQ;
  logic rxArmedQ;
  txState_e txState, txNextState;

  assign aligned = (regAddr[3:0] == 4'd0);
  assign slot    = regAddr[REG_AW-1:4];
  assign wrCtrl  = regWr && aligned && slot == SLOT_W'(SLOT_CTRL);
  assign wrTxp   = regWr && aligned && slot == SLOT_W'(SLOT_TXPTR);
  assign wrRxp   = regWr && aligned && slot == SLOT_W'(SLOT_RXPTR);
  assign wrStat  = regWr && aligned && slot == SLOT_W'(SLOT_STAT);
  assign wrMask  = regWr && aligned && slot == SLOT_W'(SLOT_MASK);

  assign txStartC = wrCtrl && wdataLo[0] && (txState == TX_IDLE) && !st.txOffZero;

  always_comb begin
    stb         = '0;
    stb.txPtrWr = wrTxp;
    stb.rxPtrWr = wrRxp;
    stb.rxArmed = rxArmedQ;
    txNextState = txState;
    case (txState)
      TX_IDLE: if (txStartC) begin
        stb.txStart = 1'b1;
        txNextState = TX_REQ;
      end
      TX_REQ: begin
        stb.txReq = 1'b1;
        if (st.txGntOk) txNextState = TX_WAIT;
      end
      TX_WAIT: if (memRvalid) begin
        stb.txWordLd = 1'b1;
        txNextState  = TX_SEND;
      end
      TX_SEND: begin
        stb.txSend = 1'b1;
        if (txReady && st.txLaneLast) begin
          if (st.txLastWord) begin
            stb.txFinish = 1'b1;
            txNextState  = TX_IDLE;
          end else begin
            stb.txNext  = 1'b1;
            txNextState = TX_REQ;
          end
        end
      end
      default: txNextState = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      ctrlQ    <= '0;
      statQ    <= '0;
      maskQ    <= '0;
      rxArmedQ <= 1'b0;
    end else begin
      txState <= txNextState;
      if (wrCtrl) ctrlQ <= wdataLo;
      if (stb.txFinish) ctrlQ[0] <= 1'b0;
      if (wrCtrl) statQ[0] <= 1'b0;
      if (wrStat) statQ <= statQ & ~wdataLo;
      if (stb.txFinish) statQ[0] <= 1'b1;
      if (st.rxHalf) statQ[1] <= 1'b1;
      if (wrMask) maskQ <= wdataLo;
      if (st.rxEnd) rxArmedQ <= 1'b0;
      else if (wrCtrl && wdataLo[1]) rxArmedQ <= 1'b1;
    end
  end

  assign irq = |(statQ & maskQ);

  always_comb begin
    regRdata = '0;
    if (aligned) begin
      case (slot)
        SLOT_W'(SLOT_CTRL):  regRdata = {30'd0, ctrlQ};
        SLOT_W'(SLOT_TXPTR): regRdata = txPtr;
        SLOT_W'(SLOT_RXPTR): regRdata = rxPtr;
        SLOT_W'(SLOT_STAT):  regRdata = {30'd0, statQ};
        SLOT_W'(SLOT_MASK):  regRdata = {30'd0, maskQ};
        default:             regRdata = '0;
      endcase
    end
  end

  a_r7_tx_finish: assert property (@(posedge clk) disable iff (!rstN)
    stb.txFinish |=> (!ctrlQ[0] && statQ[0]));
  a_r4_ctrl_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !stb.txFinish) |=> !statQ[0]);
  a_r6_zero_offset: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && wdataLo[0] && st.txOffZero && txState == TX_IDLE) |=> (txState == TX_IDLE));
  a_r11_half_page: assert property (@(posedge clk) disable iff (!rstN)
    st.rxHalf |=> statQ[1]);
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wdataLo[1] && !st.rxHalf) |=> !statQ[1]);

endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
  import sdma_pkg::*;
#(
  parameter int unsigned REG_AW    = 8,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [31:0]       memRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [7:0]        rxData,
  input  logic              rxIdle
);
  dmaStrobe_t  stb;
  dmaStatus_t  st;
  logic [31:0] txPtr, rxPtr;

  sdma_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .wdataLo(regWdata[1:0]), .txPtr(txPtr), .rxPtr(rxPtr), .st(st),
    .memRvalid(memRvalid), .txReady(txReady), .stb(stb),
    .regRdata(regRdata), .irq(irq)
  );

  sdma_dpath #(.PAGE_BITS(PAGE_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWdata), .st(st),
    .txPtr(txPtr), .rxPtr(rxPtr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memGnt(memGnt),
    .memRvalid(memRvalid), .memRdata(memRdata), .txValid(txValid),
    .txReady(txReady), .txData(txData), .rxValid(rxValid), .rxReady(rxReady),
    .rxData(rxData), .rxIdle(rxIdle)
  );

endmodule

// File: tb/sdma_chan_bench.sv
module sdma_chan_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq, memReq, memWe, txValid, rxReady;
  logic [31:0] memAddr, memWdata;
  logic [3:0] memBe;
  logic memGnt = 1'b0, memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic txReady = 1'b0;
  logic [7:0] txData;
  logic rxValid = 1'b0, rxIdle = 1'b0;
  logic [7:0] rxData = '0;

  always #10 clk = ~clk;

  sdma_chan u_sdma_chan (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memGnt(memGnt), .memRvalid(memRvalid),
    .memRdata(memRdata), .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxIdle(rxIdle)
  );

  int checkCnt = 0, failCnt = 0, cyc = 0;
  logic [31:0] memArr [0:4095];
  logic [7:0] expTx[$];
  int rdDue[$];
  logic [31:0] rdVal[$];
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [31:0] a);
    return ((a << 3) & ~32'h1f) | (a >> 29);
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
  endtask

  task automatic expectTx(input logic [31:0] a);
    for (logic [31:0] w = a & 32'hFFC; w <= 32'hFFC; w += 4) begin
      logic [31:0] word;
      word = memArr[((a & ~32'hFFF) | w) >> 2 & 32'hFFF];
      for (int k = 0; k < 4; k++) expTx.push_back(word[8*k +: 8]);
    end
  endtask

  task automatic sendBytes(input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1; rxData = first + 8'(i);
      while (!rxReady) @(negedge clk);
      @(negedge clk);
    end
    rxValid = 1'b0;
  endtask

  task automatic waitTxDone();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h00, v);
      if (!v[0]) break;
      repeat (4) @(negedge clk);
    end
  endtask

  // memory responder and transmit sink, compared every clock
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      memRvalid = 1'b0;
      if (rdDue.size() > 0 && rdDue[0] == cyc) begin
        void'(rdDue.pop_front());
        memRvalid = 1'b1;
        memRdata = rdVal.pop_front();
      end
      memGnt = memReq && (cyc % 3 != 1);
      if (memGnt && memWe) begin
        for (int k = 0; k < 4; k++)
          if (memBe[k]) memArr[memAddr[13:2]][8*k +: 8] = memWdata[8*k +: 8];
      end else if (memGnt) begin
        rdDue.push_back(cyc + 2);
        rdVal.push_back(memArr[memAddr[13:2]]);
      end
      txReady = (cyc % 4 != 2);
      if (txValid && txReady) begin
        if (expTx.size() > 0) check("R5 tx byte", {24'd0, txData}, {24'd0, expTx.pop_front()});
        else check("R5/R6 unexpected tx byte", {24'd0, txData}, 32'hFFFF_FFFF);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      finishRun();
    end
  end

  initial begin
    logic [31:0] v, p;
    for (int i = 0; i < 4096; i++) memArr[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd(8'(s * 16), v);
      check("R1 reset reg", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R1 mask readback", v, 32'd3);
    wr(8'h40, 32'd0);
    // R2 misaligned
    wr(8'h41, 32'd3);
    rd(8'h40, v); check("R2 misaligned write ignored", v, 32'd0);
    wr(8'h10, 32'h1234_5678);
    rd(8'h14, v); check("R2 misaligned read zero", v, 32'd0);

    // R6 zero offset
    wr(8'h10, enc(32'h0000_2000));
    wr(8'h00, 32'd1);
    repeat (30) @(negedge clk);
    rd(8'h00, v); check("R6 enable stays set", v, 32'd1);
    rd(8'h30, v); check("R6 no completion", v, 32'd0);

    // R5/R7/R3 transmit from a nonzero offset
    expectTx(32'hA000_1F04);
    wr(8'h10, enc(32'hA000_1F04));
    wr(8'h00, 32'd1);
    waitTxDone();
    check("R5 tx length", 32'(expTx.size()), 32'd0);
    rd(8'h30, v); check("R7 status set", v, 32'd1);
    rd(8'h00, v); check("R7 enable cleared", v, 32'd0);
    rd(8'h10, v); check("R7 R3 next page pointer", v, enc(32'hA000_2000));
    wr(8'h40, 32'd1);
    check("R13 irq after mask", {31'd0, irq}, 32'd1);
    wr(8'h40, 32'd0);
    check("R13 irq masked", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'd0);
    rd(8'h30, v); check("R4 control write clears", v, 32'd0);

    // R5 unaligned offset: one word only
    expectTx(32'h0000_1FFD);
    wr(8'h10, enc(32'h0000_1FFD) | 32'h08);
    wr(8'h00, 32'd1);
    waitTxDone();
    check("R5 unaligned length", 32'(expTx.size()), 32'd0);
    rd(8'h10, v); check("R7 pointer after unaligned", v, enc(32'h0000_2000));
    wr(8'h30, 32'd1);
    rd(8'h30, v); check("R12 clear tx bit", v, 32'd0);

    // R8/R10 receive with partial flush
    p = memArr[32'h3014 >> 2 & 32'hFFF];
    wr(8'h20, enc(32'h0000_3010));
    wr(8'h00, 32'd2);
    sendBytes(8'h10, 6);
    repeat (10) @(negedge clk);
    check("R8 full word", memArr[32'h3010 >> 2], 32'h1312_1110);
    rd(8'h20, v); check("R8 pointer plus 4", v, enc(32'h0000_3014));
    rd(8'h00, v); check("R8 enable kept", v, 32'd2);
    rxIdle = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 not ready when idle", {31'd0, rxReady}, 32'd0);
    check("R10 partial word", memArr[32'h3014 >> 2], {p[31:16], 16'h1514});
    rd(8'h20, v); check("R10 pointer plus n", v, enc(32'h0000_3016));
    rxIdle = 1'b0;
    @(negedge clk);
    check("R10 transfer ended", {31'd0, rxReady}, 32'd0);
    rd(8'h30, v); check("R11 no crossing", v, 32'd0);

    // R11/R12 half-page crossing
    wr(8'h20, enc(32'h0000_37F8));
    wr(8'h00, 32'd2);
    sendBytes(8'h40, 8);
    repeat (10) @(negedge clk);
    rd(8'h30, v); check("R11 half page set", v, 32'd2);
    check("R8 word at 0x37FC", memArr[32'h37FC >> 2], 32'h4746_4544);
    rd(8'h20, v); check("R8 pointer at half", v, enc(32'h0000_3800));
    wr(8'h30, 32'd1);
    rd(8'h30, v); check("R12 other bit kept", v, 32'd2);
    wr(8'h40, 32'd2);
    check("R13 irq rx half", {31'd0, irq}, 32'd1);
    wr(8'h30, 32'd2);
    rd(8'h30, v); check("R12 clear rx bit", v, 32'd0);
    check("R13 irq drops", {31'd0, irq}, 32'd0);
    wr(8'h40, 32'd0);
    rxIdle = 1'b1; repeat (4) @(negedge clk); rxIdle = 1'b0;

    // R9 page end
    wr(8'h20, enc(32'h0000_3FF8));
    wr(8'h00, 32'd2);
    sendBytes(8'h60, 8);
    repeat (10) @(negedge clk);
    check("R9 stopped at page end", {31'd0, rxReady}, 32'd0);
    rd(8'h20, v); check("R9 pointer next page", v, enc(32'h0000_4000));
    check("R9 last word", memArr[32'h3FFC >> 2 & 32'hFFF], 32'h6766_6564);
    rd(8'h30, v); check("R11 crossing at page end", v, 32'd2);
    wr(8'h30, 32'd3);

    // R14 both directions sharing the port
    expectTx(32'h0000_1E00);
    wr(8'h10, enc(32'h0000_1E00));
    wr(8'h20, enc(32'h0000_2400));
    wr(8'h00, 32'd3);
    sendBytes(8'h80, 8);
    rxIdle = 1'b1;
    waitTxDone();
    rxIdle = 1'b0;
    check("R14 tx complete", 32'(expTx.size()), 32'd0);
    check("R14 rx word 0", memArr[32'h2400 >> 2], 32'h8382_8180);
    check("R14 rx word 1", memArr[32'h2404 >> 2], 32'h8786_8584);
    rd(8'h10, v); check("R14 tx pointer", v, enc(32'h0000_2000));
    rd(8'h20, v); check("R14 rx pointer", v, enc(32'h0000_2408));

    repeat (5) @(negedge clk);
    done = 1;
    finishRun();
  end
endmodule